// File: doc/BRIEF.md
# Video Raster Timing Detector

This block observes a parallel digital video sample stream, one sample per clock, and measures its raster: total samples per line, active samples per line, total lines per frame and active lines per frame. The raster can be taken from external horizontal-blanking, vertical-blanking and field strobes. It can also be taken from timing-reference code words embedded in the sample data, in either their 10-bit or their 8-bit form. A mode input picks the source. A configuration input picks how the external horizontal strobe frames the blanking interval.

A state machine with three states drives the block. **ST_IDLE** waits for a frame boundary. **ST_ACQUIRE** measures one full frame. **ST_LOCKED** publishes the measurements and checks every new line and frame against them. The transitions are:

- **T_START** (ST_IDLE to ST_ACQUIRE): a frame boundary is seen.
- **T_LOCK** (ST_ACQUIRE to ST_LOCKED): the next boundary arrives with a valid line measurement.
- **T_REACQ** (ST_ACQUIRE to itself): a boundary arrives without a valid line measurement.
- **T_SLIP** (ST_LOCKED to ST_IDLE): a line's measurement differs from the stored one.
- **T_CHANGE** (ST_LOCKED to ST_ACQUIRE): a frame's line counts differ from the stored ones.
- **T_LOSS** (any state to ST_IDLE): the reference timeout expires.

While the block is not locked, all four counts read zero.

Top module: `vid_raster_detect`

## Requirements
- R1: After reset the lock output is low and all four count outputs are zero.
- R2: With the mode input low and the H-convention input low, the line total is the number of samples from one rising edge of the H strobe to the next. The active count is the number of samples in a line during which H is low.
- R3: With the mode input low and the H-convention input high, the H strobe spans only the EAV-to-SAV interval. The active count is then the number of H-low samples minus 8, which is two four-word code words.
- R4: With the mode input high, a 10-bit code word is the sequence 3FF, 000, 000, then a fourth word. In the fourth word, bit 9 is 1, bit 8 is F, bit 7 is V, and bit 6 is H (1 marks EAV, 0 marks SAV). The line total is counted from fourth word to fourth word of successive EAVs. The active count is the number of samples between an SAV and the next EAV.
- R5: In embedded mode, a code word whose first word has its upper eight bits all ones (for example 3FC, the 8-bit form) followed by two 000 words is recognised in the same way, and gives the same measurements.
- R6: A frame begins at the line whose start sees V rise from 0 to 1 while F is 0. The frame line total is the number of lines between two such starts. The active line count is the number of those lines that began with V low.
- R7: Lock is not asserted at the first frame boundary. It rises one clock after the line start of the second boundary, so one complete frame must be measured first.
- R8: While unlocked, all four count outputs are zero. While locked, they hold the values stored at lock and do not change.
- R9: While locked, a completed line whose total or active count differs from the stored value drops lock and returns the block to waiting for a frame boundary. A full frame must be measured again before lock returns.
- R10: While locked, a frame boundary whose line total or active line count differs from the stored value drops lock and starts a new acquisition at that same boundary. Lock returns at the next boundary with the new counts.
- R11: If no horizontal reference event (an H edge, or a code word in embedded mode) occurs for the timeout limit, lock drops and all counts read zero. The limit is the timeout input when that input is nonzero. Otherwise it is twice the stored line total while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_emb_i | input | 1 | 1: embedded code words, 0: external strobes |
| hcfg_trs_i | input | 1 | External H convention: 0 whole blanking, 1 EAV-to-SAV span |
| h_blank_i | input | 1 | External horizontal-blanking strobe |
| v_blank_i | input | 1 | External vertical-blanking strobe |
| f_field_i | input | 1 | External field strobe |
| data_i | input | DATA_W | Parallel video sample |
| timeout_cfg_i | input | SAMPLE_W+1 | Reference timeout in clocks; 0 selects automatic |
| lock_o | output | 1 | Raster measured and stable |
| line_total_o | output | SAMPLE_W | Samples per line |
| line_active_o | output | SAMPLE_W | Active samples per line |
| frame_lines_o | output | LINE_W | Lines per frame |
| frame_active_o | output | LINE_W | Active lines per frame |

## Verification
The hardest case to reach is the recovery path after a slipped line. The bench locks on a clean raster and then stretches a single line by two samples in the middle of a frame. It checks that lock falls at the start of the following line and stays low through the next frame boundary. Lock must return only after a further complete frame. The timeout window is probed the same way. The stream is held still for a count of clocks chosen on each side of the limit, measured from the last H falling edge, first with the automatic limit and then with a programmed one.

// File: rtl/vid_raster_pkg.sv
package vid_raster_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_LOCKED
    } rtd_state_t;

    // code word overhead in samples
    localparam int TRS_LEN = 4;

endpackage

// File: rtl/vrd_trs_decode.sv
module vrd_trs_decode #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o,
    output logic              f_o,
    output logic              v_o,
    output logic              h_o
);
    localparam int HI  = DATA_W - 1;
    localparam int LO8 = DATA_W - 8;

    logic [DATA_W-1:0] w1_q, w2_q;
    logic [7:0]        w3_q;
    logic              preamble;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w1_q <= '0;
            w2_q <= '0;
            w3_q <= '0;
        end else begin
            w3_q <= w2_q[HI:LO8];
            w2_q <= w1_q;
            w1_q <= data_i;
        end
    end

    // upper eight bits all ones covers both the 10-bit and 8-bit forms
    always_comb begin
        preamble = (w3_q == 8'hFF) && (w2_q == '0) && (w1_q == '0);
        hit_o    = preamble && data_i[HI];
        f_o      = data_i[HI-1];
        v_o      = data_i[HI-2];
        h_o      = data_i[HI-3];
    end

endmodule

// File: rtl/vrd_ref_front.sv
module vrd_ref_front
    import vid_raster_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_emb_i,
    input  logic                hcfg_trs_i,
    input  logic                h_i,
    input  logic                v_i,
    input  logic                f_i,
    input  logic                trs_hit_i,
    input  logic                trs_f_i,
    input  logic                trs_v_i,
    input  logic                trs_h_i,
    output logic                line_start_o,
    output logic                act_start_o,
    output logic                v_o,
    output logic                f_o,
    output logic [SAMPLE_W-1:0] corr_o
);
    logic h_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) h_prev_q <= 1'b0;
        else        h_prev_q <= h_i;
    end

    always_comb begin
        if (mode_emb_i) begin
            line_start_o = trs_hit_i && trs_h_i;
            act_start_o  = trs_hit_i && !trs_h_i;
            v_o          = trs_v_i;
            f_o          = trs_f_i;
            corr_o       = SAMPLE_W'(TRS_LEN);
        end else begin
            line_start_o = h_i && !h_prev_q;
            act_start_o  = !h_i && h_prev_q;
            v_o          = v_i;
            f_o          = f_i;
            corr_o       = hcfg_trs_i ? SAMPLE_W'(2 * TRS_LEN) : '0;
        end
    end

endmodule

// File: rtl/vrd_line_meas.sv
module vrd_line_meas #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start_i,
    input  logic                act_start_i,
    input  logic [SAMPLE_W-1:0] corr_i,
    output logic                line_ok_o,
    output logic [SAMPLE_W-1:0] line_total_o,
    output logic [SAMPLE_W-1:0] line_active_o
);
    logic [SAMPLE_W-1:0] cnt_line_q, cnt_act_q;
    logic                seen_line_q, seen_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_line_q  <= '0;
            cnt_act_q   <= '0;
            seen_line_q <= 1'b0;
            seen_act_q  <= 1'b0;
        end else begin
            if (line_start_i) begin
                cnt_line_q  <= SAMPLE_W'(1);
                seen_line_q <= 1'b1;
                seen_act_q  <= 1'b0;
            end else if (cnt_line_q != '1) begin
                cnt_line_q <= cnt_line_q + 1'b1;
            end
            if (act_start_i) begin
                cnt_act_q  <= SAMPLE_W'(1);
                seen_act_q <= 1'b1;
            end else if (cnt_act_q != '1) begin
                cnt_act_q <= cnt_act_q + 1'b1;
            end
        end
    end

    always_comb begin
        line_ok_o     = seen_line_q && seen_act_q;
        line_total_o  = cnt_line_q;
        line_active_o = (cnt_act_q > corr_i) ? (cnt_act_q - corr_i) : '0;
    end

endmodule

// File: rtl/vid_raster_detect.sv
module vid_raster_detect
    import vid_raster_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SAMPLE_W    = 16,
    parameter int LINE_W      = 12,
    parameter int DEF_TIMEOUT = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_emb_i,
    input  logic                hcfg_trs_i,
    input  logic                h_blank_i,
    input  logic                v_blank_i,
    input  logic                f_field_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [SAMPLE_W:0]   timeout_cfg_i,
    output logic                lock_o,
    output logic [SAMPLE_W-1:0] line_total_o,
    output logic [SAMPLE_W-1:0] line_active_o,
    output logic [LINE_W-1:0]   frame_lines_o,
    output logic [LINE_W-1:0]   frame_active_o
);
    localparam int TO_W = SAMPLE_W + 1;

    logic                trs_hit, trs_f, trs_v, trs_h;
    logic                line_start, act_start, v_now, f_now;
    logic [SAMPLE_W-1:0] corr;
    logic                line_ok;
    logic [SAMPLE_W-1:0] meas_total, meas_active;

    rtd_state_t          st_q, st_d;
    logic                v_line_q;
    logic [LINE_W-1:0]   lcnt_q, acnt_q;
    logic [SAMPLE_W-1:0] keep_len_q, keep_act_q;
    logic [LINE_W-1:0]   keep_lines_q, keep_alines_q;
    logic [TO_W-1:0]     idle_q, tmo_limit;
    logic                ref_evt, frame_bnd, line_slip, frame_change, tmo_expire;

    vrd_trs_decode #(.DATA_W(DATA_W)) u_trs (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (data_i),
        .hit_o  (trs_hit),
        .f_o    (trs_f),
        .v_o    (trs_v),
        .h_o    (trs_h)
    );

    vrd_ref_front #(.SAMPLE_W(SAMPLE_W)) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_emb_i   (mode_emb_i),
        .hcfg_trs_i   (hcfg_trs_i),
        .h_i          (h_blank_i),
        .v_i          (v_blank_i),
        .f_i          (f_field_i),
        .trs_hit_i    (trs_hit),
        .trs_f_i      (trs_f),
        .trs_v_i      (trs_v),
        .trs_h_i      (trs_h),
        .line_start_o (line_start),
        .act_start_o  (act_start),
        .v_o          (v_now),
        .f_o          (f_now),
        .corr_o       (corr)
    );

    vrd_line_meas #(.SAMPLE_W(SAMPLE_W)) u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start_i  (line_start),
        .act_start_i   (act_start),
        .corr_i        (corr),
        .line_ok_o     (line_ok),
        .line_total_o  (meas_total),
        .line_active_o (meas_active)
    );

    // event decode
    always_comb begin
        ref_evt      = line_start || act_start;
        frame_bnd    = line_start && v_now && !v_line_q && !f_now;
        line_slip    = line_start && line_ok &&
                       ((meas_total != keep_len_q) || (meas_active != keep_act_q));
        frame_change = frame_bnd &&
                       ((lcnt_q != keep_lines_q) || (acnt_q != keep_alines_q));
        if (timeout_cfg_i != '0)
            tmo_limit = timeout_cfg_i;
        else if (st_q == ST_LOCKED)
            tmo_limit = {keep_len_q, 1'b0};
        else
            tmo_limit = TO_W'(DEF_TIMEOUT);
        tmo_expire = !ref_evt && (idle_q >= tmo_limit);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (frame_bnd) st_d = ST_ACQUIRE;              // T_START
            end
            ST_ACQUIRE: begin
                if (frame_bnd && line_ok) st_d = ST_LOCKED;    // T_LOCK
                else                      st_d = ST_ACQUIRE;   // T_REACQ / wait
            end
            ST_LOCKED: begin
                if (line_slip)         st_d = ST_IDLE;         // T_SLIP
                else if (frame_change) st_d = ST_ACQUIRE;      // T_CHANGE
            end
            default: st_d = ST_IDLE;
        endcase
        if (tmo_expire) st_d = ST_IDLE;                        // T_LOSS
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // measurement registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_line_q      <= 1'b1;
            lcnt_q        <= '0;
            acnt_q        <= '0;
            keep_len_q    <= '0;
            keep_act_q    <= '0;
            keep_lines_q  <= '0;
            keep_alines_q <= '0;
            idle_q        <= '0;
        end else begin
            if (ref_evt)              idle_q <= '0;
            else if (idle_q != '1)    idle_q <= idle_q + 1'b1;

            if (line_start) v_line_q <= v_now;

            if (frame_bnd) begin
                lcnt_q <= LINE_W'(1);
                acnt_q <= '0;
            end else if (line_start) begin
                if (lcnt_q != '1)              lcnt_q <= lcnt_q + 1'b1;
                if (!v_now && acnt_q != '1)    acnt_q <= acnt_q + 1'b1;
            end

            if (st_q == ST_ACQUIRE && st_d == ST_LOCKED) begin
                keep_len_q    <= meas_total;
                keep_act_q    <= meas_active;
                keep_lines_q  <= lcnt_q;
                keep_alines_q <= acnt_q;
            end
        end
    end

    // outputs
    always_comb begin
        lock_o = (st_q == ST_LOCKED);
        if (lock_o) begin
            line_total_o   = keep_len_q;
            line_active_o  = keep_act_q;
            frame_lines_o  = keep_lines_q;
            frame_active_o = keep_alines_q;
        end else begin
            line_total_o   = '0;
            line_active_o  = '0;
            frame_lines_o  = '0;
            frame_active_o = '0;
        end
    end

endmodule

// File: rtl/vrd_checker.sv
module vrd_checker #(
    parameter int SAMPLE_W = 16,
    parameter int LINE_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lock,
    input logic [SAMPLE_W-1:0] line_total,
    input logic [SAMPLE_W-1:0] line_active,
    input logic [LINE_W-1:0]   frame_lines,
    input logic [LINE_W-1:0]   frame_active,
    input logic                frame_bnd,
    input logic                line_start,
    input logic                tmo_expire
);

    p_lock_after_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(frame_bnd));

    p_zero_when_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> (line_total == '0 && line_active == '0 &&
                   frame_lines == '0 && frame_active == '0));

    p_hold_while_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> ($stable(line_total) && $stable(line_active) &&
                                   $stable(frame_lines) && $stable(frame_active)));

    p_drop_only_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !line_start && !frame_bnd && !tmo_expire) |=> lock);

    p_timeout_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> !lock);

endmodule

bind vid_raster_detect vrd_checker #(.SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock         (lock_o),
    .line_total   (line_total_o),
    .line_active  (line_active_o),
    .frame_lines  (frame_lines_o),
    .frame_active (frame_active_o),
    .frame_bnd    (frame_bnd),
    .line_start   (line_start),
    .tmo_expire   (tmo_expire)
);

// File: tb/vid_raster_detect_tb_top.sv
`timescale 1ns/1ps
module vid_raster_detect_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_emb = 1'b0;
    logic        hcfg = 1'b0;
    logic        h_b = 1'b0;
    logic        v_b = 1'b0;
    logic        f_b = 1'b0;
    logic [9:0]  data = '0;
    logic [16:0] tcfg = '0;
    logic        lock;
    logic [15:0] l_tot, l_act;
    logic [11:0] f_lines, f_act;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vid_raster_detect dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_emb_i     (mode_emb),
        .hcfg_trs_i     (hcfg),
        .h_blank_i      (h_b),
        .v_blank_i      (v_b),
        .f_field_i      (f_b),
        .data_i         (data),
        .timeout_cfg_i  (tcfg),
        .lock_o         (lock),
        .line_total_o   (l_tot),
        .line_active_o  (l_act),
        .frame_lines_o  (f_lines),
        .frame_active_o (f_act)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit emb, input bit hc, input int to);
        rst_n = 1'b0; mode_emb = emb; hcfg = hc; tcfg = 17'(to);
        h_b = 1'b0; v_b = 1'b0; f_b = 1'b0; data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        h_b = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic line_ext(input int total, input int hhi, input bit v);
        for (int i = 0; i < total; i++) begin
            h_b = (i < hhi); v_b = v; f_b = 1'b0;
            @(negedge clk);
        end
    endtask

    // lines first..nl-1 of an 8-line-style frame, vl blanking lines at top
    task automatic frame_ext(input int nl, input int vl, input int first,
                             input int total, input int hhi);
        for (int l = first; l < nl; l++) line_ext(total, hhi, l < vl);
    endtask

    task automatic put(input logic [9:0] w);
        data = w;
        @(negedge clk);
    endtask

    // 24 samples: EAV(4) blank(4) SAV(4) active(12)
    task automatic line_emb(input bit v, input bit eight);
        logic [9:0] pre;
        pre = eight ? 10'h3FC : 10'h3FF;
        put(pre); put(10'h000); put(10'h000); put({1'b1, 1'b0, v, 1'b1, 6'b0});
        repeat (4) put(10'h040);
        put(pre); put(10'h000); put(10'h000); put({1'b1, 1'b0, v, 1'b0, 6'b0});
        repeat (12) put(10'h200);
    endtask

    task automatic frame_emb(input bit eight, input int first);
        for (int l = first; l < 8; l++) line_emb(l < 2, eight);
    endtask

    // two frames plus the next frame's first line reach lock
    task automatic lock_ext(input int total, input int hhi);
        frame_ext(8, 2, 0, total, hhi);
        frame_ext(8, 2, 0, total, hhi);
        line_ext(total, hhi, 1'b1);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 0);
        chk("R1 lock", lock, 0);
        chk("R1 line_total", l_tot, 0);
        chk("R1 line_active", l_act, 0);
        chk("R1 frame_lines", f_lines + f_act, 0);
    endtask

    task automatic t_ext_basic();
        do_reset(1'b0, 1'b0, 0);
        frame_ext(8, 2, 0, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R7 no lock after first boundary", lock, 0);
        chk("R8 zero while acquiring", l_tot, 0);
        frame_ext(8, 2, 1, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R7 lock after full frame", lock, 1);
        chk("R2 line total", l_tot, 20);
        chk("R2 line active", l_act, 14);
        chk("R6 frame lines", f_lines, 8);
        chk("R6 frame active lines", f_act, 6);
    endtask

    task automatic t_ext_trs_h();
        do_reset(1'b0, 1'b1, 0);
        lock_ext(20, 6);
        chk("R3 lock", lock, 1);
        chk("R3 line total", l_tot, 20);
        chk("R3 line active", l_act, 6);
    endtask

    task automatic t_emb(input bit eight);
        do_reset(1'b1, 1'b0, 0);
        frame_emb(eight, 0);
        frame_emb(eight, 0);
        line_emb(1'b1, eight);
        if (eight) begin
            chk("R5 lock", lock, 1);
            chk("R5 line total", l_tot, 24);
            chk("R5 line active", l_act, 12);
            chk("R5 frame lines", f_lines, 8);
        end else begin
            chk("R4 lock", lock, 1);
            chk("R4 line total", l_tot, 24);
            chk("R4 line active", l_act, 12);
            chk("R4 frame lines", f_lines, 8);
            chk("R4 frame active lines", f_act, 6);
        end
    endtask

    task automatic t_line_slip();
        do_reset(1'b0, 1'b0, 0);
        lock_ext(20, 6);
        chk("R9 locked before slip", lock, 1);
        line_ext(22, 6, 1'b1);
        line_ext(20, 6, 1'b0);
        chk("R9 lock dropped", lock, 0);
        chk("R9 counts cleared", l_tot, 0);
        frame_ext(8, 2, 3, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R9 no relock at first boundary", lock, 0);
        frame_ext(8, 2, 1, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R9 relock", lock, 1);
        chk("R9 relock total", l_tot, 20);
    endtask

    task automatic t_frame_change();
        do_reset(1'b0, 1'b0, 0);
        lock_ext(20, 6);
        frame_ext(8, 2, 1, 20, 6);
        frame_ext(9, 2, 0, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R10 lock dropped", lock, 0);
        frame_ext(9, 2, 1, 20, 6);
        line_ext(20, 6, 1'b1);
        chk("R10 relock", lock, 1);
        chk("R10 new frame lines", f_lines, 9);
        chk("R10 new active lines", f_act, 7);
    endtask

    task automatic t_timeout();
        do_reset(1'b0, 1'b0, 0);
        lock_ext(20, 6);
        idle(20);
        chk("R11 auto limit not reached", lock, 1);
        idle(30);
        chk("R11 auto limit lock", lock, 0);
        chk("R11 auto limit counts", l_tot, 0);
        do_reset(1'b0, 1'b0, 100);
        lock_ext(20, 6);
        idle(60);
        chk("R11 programmed limit not reached", lock, 1);
        idle(50);
        chk("R11 programmed limit lock", lock, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ext_basic();
        t_ext_trs_h();
        t_emb(1'b0);
        t_emb(1'b1);
        t_line_slip();
        t_frame_change();
        t_timeout();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule